// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the purely combinational arithmetic and logic stage of a small 8-bit controller core. Each evaluation takes a destination operand, a source operand (a register value or an immediate chosen upstream), a 4-bit operation code and the current status byte. It returns the 8-bit result, a write strobe that says whether the result should go back to the destination register, and the next status byte.

The operations cover binary addition and subtraction, each with and without the incoming carry. The compare variants compute the flags of a subtraction but never request a writeback. The block also provides bitwise AND, OR and XOR, one's complement, two's complement negation, and three right shifts. Carry, half carry and overflow come from fixed Boolean equations on bits 7 and 3 of the operands and the result. Zero, negative and sign are derived from the result for every flag-writing operation.

Decoding of instruction words, the register file and single-bit flag instructions are outside the block. The owning pipeline stage registers the outputs.

Top module: `alu8_core`

## Requirements
- R1: Status byte bit positions: bit 0 carry C, bit 1 zero Z, bit 2 negative N, bit 3 overflow V, bit 4 sign S, bit 5 half carry H, bit 6 T, bit 7 I. Op code 0 (add) yields rd+rr and op code 1 (add with carry) yields rd+rr+C, modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when the signed sum lies outside -128..127.
- R2: Op code 2 (subtract) yields rd-rr and op code 3 (subtract with carry) yields rd-rr-C, modulo 256. C is set when the unsigned difference borrows. H is set on a borrow out of the low nibble, and V is set when the signed difference lies outside -128..127.
- R3: Op codes 4 (compare) and 5 (compare with carry) produce the same result and flags as op codes 2 and 3, with the write strobe at 0. Every other defined op code 0..13 drives the write strobe to 1.
- R4: Op codes 6, 7 and 8 yield rd AND rr, rd OR rr and rd XOR rr. V is 0, and C and H keep their incoming values.
- R5: Op code 9 yields the bitwise inverse of rd, with C forced to 1, V to 0 and H unchanged.
- R6: Op code 10 yields 0-rd modulo 256, with C, H and V following the subtraction rules of R2 for the operands 0 and rd.
- R7: Op codes 11, 12 and 13 shift rd right by one place and insert, as the new bit 7, the old bit 7, a 0 and the incoming C respectively. C takes the old bit 0, V equals the new C XOR the new N, and H is unchanged.
- R8: For every op code 0..13, N equals result bit 7, Z is 1 exactly when the result is 0, and S equals N XOR V.
- R9: Status bits T and I always pass from input to output unchanged.
- R10: Op codes 14 and 15 are reserved. They drive the write strobe to 0, return the status byte unchanged and present rd on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd_i | input | 8 | Destination operand |
| rr_i | input | 8 | Source operand (register or immediate) |
| op_i | input | 4 | Operation code, encoding as in the requirements |
| sreg_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Operation result |
| wr_en_o | output | 1 | Result should be written to the destination register |
| sreg_o | output | 8 | Next status byte |

## Verification
The embedded checks presume that all inputs are two-valued and settled when they are evaluated, which holds because the block has no state and the stimulus changes inputs only in blocking steps separated by a delay. The carry and borrow checks inside the adder/subtractor compare the Boolean flag equations against a wide arithmetic sum, so they rely on the carry-in already being chosen by the operation. The sweep keeps to that by covering every destination value against a spread of source values, including the sign and nibble boundaries, with both carry states and all 16 op codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int MSB   = DW - 1;
    localparam int HB    = DW / 2 - 1;
    localparam int OPW   = 4;

    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;
    localparam int FT = 6;
    localparam int FI = 7;

    typedef logic [DW-1:0] word_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_CPC  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_COM  = 4'd9,
        OP_NEG  = 4'd10,
        OP_ASR  = 4'd11,
        OP_LSR  = 4'd12,
        OP_ROR  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        word_t sum;
        logic  c;
        logic  h;
        logic  v;
    } arith_out_t;

    typedef struct packed {
        word_t res;
        logic  c;
    } shift_out_t;

    function automatic logic carry_of_add(input logic d, input logic r, input logic x);
        return (d & r) | (r & ~x) | (~x & d);
    endfunction

    function automatic logic borrow_of_sub(input logic d, input logic r, input logic x);
        return (~d & r) | (r & x) | (x & ~d);
    endfunction

    function automatic logic ovf_of_add(input logic d, input logic r, input logic x);
        return (d & r & ~x) | (~d & ~r & x);
    endfunction

    function automatic logic ovf_of_sub(input logic d, input logic r, input logic x);
        return (d & ~r & ~x) | (~d & r & x);
    endfunction

    function automatic logic op_is_defined(input alu_op_e op);
        return op != OP_RSV0 && op != OP_RSV1;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  word_t      a_i,
    input  word_t      b_i,
    input  logic       sub_i,
    input  logic       cin_i,
    output arith_out_t out_o
);

    localparam int XW = DW + 1;

    word_t          b_eff;
    logic [XW-1:0]  wide;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
    end

    always_comb begin
        out_o.sum = wide[DW-1:0];
        if (sub_i) begin
            out_o.c = borrow_of_sub(a_i[MSB], b_i[MSB], out_o.sum[MSB]);
            out_o.h = borrow_of_sub(a_i[HB],  b_i[HB],  out_o.sum[HB]);
            out_o.v = ovf_of_sub(a_i[MSB], b_i[MSB], out_o.sum[MSB]);
        end else begin
            out_o.c = carry_of_add(a_i[MSB], b_i[MSB], out_o.sum[MSB]);
            out_o.h = carry_of_add(a_i[HB],  b_i[HB],  out_o.sum[HB]);
            out_o.v = ovf_of_add(a_i[MSB], b_i[MSB], out_o.sum[MSB]);
        end
    end

    logic [XW-1:0] chk_add;
    logic [XW-1:0] chk_need;
    logic [3:0]    lo_a;
    logic [4:0]    lo_need;

    always_comb begin
        chk_add  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
        chk_need = {1'b0, b_i} + {{DW{1'b0}}, ~cin_i};
        lo_a     = a_i[3:0];
        lo_need  = {1'b0, b_i[3:0]} + {4'b0, ~cin_i};
        if (!$isunknown({a_i, b_i, sub_i, cin_i})) begin
            if (!sub_i) begin
                AST_ADD_CARRY: assert (out_o.c == chk_add[DW]); // R1
                AST_ADD_HALF: assert (out_o.h == (({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'b0, cin_i}) > 5'd15)); // R1
            end else begin
                AST_SUB_BORROW: assert (out_o.c == ({1'b0, a_i} < chk_need)); // R2
                AST_SUB_HALF: assert (out_o.h == ({1'b0, lo_a} < lo_need)); // R2
            end
        end
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e op_i,
    input  word_t   a_i,
    input  word_t   b_i,
    output word_t   res_o
);

    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_comb begin
            unique case (op_i)
                OP_AND:  res_o[i] = a_i[i] & b_i[i];
                OP_OR:   res_o[i] = a_i[i] | b_i[i];
                OP_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = ~a_i[i];
            endcase
        end
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
(
    input  alu_op_e    op_i,
    input  word_t      a_i,
    input  logic       cin_i,
    output shift_out_t out_o
);

    logic fill;

    always_comb begin
        unique case (op_i)
            OP_ASR:  fill = a_i[MSB];
            OP_ROR:  fill = cin_i;
            default: fill = 1'b0;
        endcase
        out_o.res = {fill, a_i[DW-1:1]};
        out_o.c   = a_i[0];
    end

    always_comb begin
        if (!$isunknown({a_i, cin_i}) && op_i == OP_ASR) begin
            AST_ASR_SIGN: assert ($signed(out_o.res) == ($signed(a_i) >>> 1)); // R7
        end
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] rd_i,
    input  logic [7:0] rr_i,
    input  logic [3:0] op_i,
    input  logic [7:0] sreg_i,
    output logic [7:0] res_o,
    output logic       wr_en_o,
    output logic [7:0] sreg_o
);

    alu_op_e    op;
    word_t      as_a;
    word_t      as_b;
    logic       as_sub;
    logic       as_cin;
    arith_out_t as_out;
    word_t      lg_res;
    shift_out_t sh_out;

    assign op = alu_op_e'(op_i);

    always_comb begin
        as_a   = rd_i;
        as_b   = rr_i;
        as_sub = 1'b0;
        as_cin = 1'b0;
        unique case (op)
            OP_ADC: as_cin = sreg_i[FC];
            OP_SUB, OP_CMP: begin
                as_sub = 1'b1;
                as_cin = 1'b1;
            end
            OP_SBC, OP_CPC: begin
                as_sub = 1'b1;
                as_cin = ~sreg_i[FC];
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = rd_i;
                as_sub = 1'b1;
                as_cin = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .sub_i (as_sub),
        .cin_i (as_cin),
        .out_o (as_out)
    );

    alu8_logic u_logic (
        .op_i  (op),
        .a_i   (rd_i),
        .b_i   (rr_i),
        .res_o (lg_res)
    );

    alu8_shift u_shift (
        .op_i  (op),
        .a_i   (rd_i),
        .cin_i (sreg_i[FC]),
        .out_o (sh_out)
    );

    logic  flag_c;
    logic  flag_h;
    logic  flag_v;
    word_t sel_res;
    logic  sel_wr;

    always_comb begin
        flag_c  = sreg_i[FC];
        flag_h  = sreg_i[FH];
        flag_v  = sreg_i[FV];
        sel_res = rd_i;
        sel_wr  = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
                sel_res = as_out.sum;
                flag_c  = as_out.c;
                flag_h  = as_out.h;
                flag_v  = as_out.v;
                sel_wr  = !(op == OP_CMP || op == OP_CPC);
            end
            OP_AND, OP_OR, OP_XOR: begin
                sel_res = lg_res;
                flag_v  = 1'b0;
            end
            OP_COM: begin
                sel_res = lg_res;
                flag_c  = 1'b1;
                flag_v  = 1'b0;
            end
            OP_ASR, OP_LSR, OP_ROR: begin
                sel_res = sh_out.res;
                flag_c  = sh_out.c;
                flag_v  = sh_out.c ^ sh_out.res[MSB];
            end
            default: sel_wr = 1'b0;
        endcase
    end

    always_comb begin
        res_o   = sel_res;
        wr_en_o = sel_wr;
        sreg_o  = sreg_i;
        if (op_is_defined(op)) begin
            sreg_o[FC] = flag_c;
            sreg_o[FH] = flag_h;
            sreg_o[FV] = flag_v;
            sreg_o[FZ] = ~|sel_res;
            sreg_o[FN] = sel_res[MSB];
            sreg_o[FS] = sel_res[MSB] ^ flag_v;
        end
    end

    always_comb begin
        if (!$isunknown({op_i, rd_i, rr_i, sreg_i})) begin
            if (op == OP_CMP || op == OP_CPC) begin
                AST_CMP_NO_WRITE: assert (!wr_en_o && res_o == as_out.sum); // R3
            end
            if (!op_is_defined(op)) begin
                AST_RSV_IDLE: assert (!wr_en_o && sreg_o == sreg_i); // R10
            end
        end
    end

endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;

    logic       clk;
    logic [7:0] rd;
    logic [7:0] rr;
    logic [3:0] op;
    logic [7:0] sin;
    logic [7:0] res;
    logic       wr;
    logic [7:0] sout;

    int n_chk;
    int n_bad;
    int cyc;
    bit done;

    alu8_core u_dut (
        .rd_i    (rd),
        .rr_i    (rr),
        .op_i    (op),
        .sreg_i  (sin),
        .res_o   (res),
        .wr_en_o (wr),
        .sreg_o  (sout)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk = n_chk + 1;
        if (got != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s op=%0d rd=%02h rr=%02h sreg=%02h: actual %0h expected %0h",
                     tag, what, op, rd, rr, sin, got, exp);
        end
    endtask

    function automatic int sx(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic logic [7:0] src_pick(input int k);
        if (k < 16) return 8'(k * 17);
        case (k)
            16: return 8'h01;
            17: return 8'h7F;
            18: return 8'h80;
            default: return 8'h0F;
        endcase
    endfunction

    initial begin
        n_chk = 0;
        n_bad = 0;
        cyc   = 0;
        done  = 1'b0;
        rd = '0; rr = '0; op = '0; sin = '0;
        #2;
        for (int o = 0; o < 16; o++) begin
            for (int d = 0; d < 256; d++) begin
                for (int k = 0; k < 20; k++) begin
                    for (int c = 0; c < 2; c++) begin
                        int a, b, cf, r, full, sv, e_res, e_c, e_h, e_v, e_wr, e_n, e_z, e_s;
                        logic [7:0] e_sreg;
                        string tag;
                        a  = d;
                        b  = int'(src_pick(k));
                        cf = c;
                        op  = 4'(o);
                        rd  = 8'(a);
                        rr  = 8'(b);
                        sin = (8'(a) ^ 8'(b << 1) ^ 8'h5A) & 8'hFE | 8'(cf);
                        e_c = int'(sin[0]);
                        e_h = int'(sin[5]);
                        e_v = int'(sin[3]);
                        e_wr = 1;
                        e_res = a;
                        tag = "R1";
                        case (o)
                            0, 1: begin
                                int ci;
                                ci = (o == 1) ? cf : 0;
                                full = a + b + ci;
                                e_res = full & 255;
                                e_c = (full > 255) ? 1 : 0;
                                e_h = (((a & 15) + (b & 15) + ci) > 15) ? 1 : 0;
                                sv = sx(a) + sx(b) + ci;
                                e_v = (sv > 127 || sv < -128) ? 1 : 0;
                            end
                            2, 3, 4, 5, 10: begin
                                int bw, x, y;
                                bw = (o == 3 || o == 5) ? cf : 0;
                                x = (o == 10) ? 0 : a;
                                y = (o == 10) ? a : b;
                                full = x - y - bw;
                                e_res = full & 255;
                                e_c = (full < 0) ? 1 : 0;
                                e_h = (((x & 15) - (y & 15) - bw) < 0) ? 1 : 0;
                                sv = sx(x) - sx(y) - bw;
                                e_v = (sv > 127 || sv < -128) ? 1 : 0;
                                tag = (o == 10) ? "R6" : ((o >= 4) ? "R3" : "R2");
                                if (o == 4 || o == 5) e_wr = 0;
                            end
                            6, 7, 8: begin
                                e_res = (o == 6) ? (a & b) : ((o == 7) ? (a | b) : (a ^ b));
                                e_v = 0;
                                tag = "R4";
                            end
                            9: begin
                                e_res = 255 - a;
                                e_c = 1;
                                e_v = 0;
                                tag = "R5";
                            end
                            11, 12, 13: begin
                                int top;
                                top = (o == 11) ? (a / 128) : ((o == 12) ? 0 : cf);
                                e_res = top * 128 + a / 2;
                                e_c = a % 2;
                                e_v = e_c ^ (e_res / 128);
                                tag = "R7";
                            end
                            default: begin
                                e_wr = 0;
                                tag = "R10";
                            end
                        endcase
                        e_sreg = sin;
                        if (o < 14) begin
                            e_n = e_res / 128;
                            e_z = (e_res == 0) ? 1 : 0;
                            e_s = e_n ^ e_v;
                            e_sreg[0] = e_c[0];
                            e_sreg[1] = e_z[0];
                            e_sreg[2] = e_n[0];
                            e_sreg[3] = e_v[0];
                            e_sreg[4] = e_s[0];
                            e_sreg[5] = e_h[0];
                        end
                        #2;
                        check(tag, "result", int'(res), e_res);
                        check((o == 4 || o == 5) ? "R3" : tag, "write", int'(wr), e_wr);
                        check(tag, "C/V/H", int'({sout[5], sout[3], sout[0]}),
                              int'({e_sreg[5], e_sreg[3], e_sreg[0]}));
                        check((o < 14) ? "R8" : "R10", "N/Z/S", int'({sout[4], sout[2], sout[1]}),
                              int'({e_sreg[4], e_sreg[2], e_sreg[1]}));
                        check("R9", "T/I", int'(sout[7:6]), int'(sin[7:6]));
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule